// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences one successive-approximation conversion. It resolves a 12-bit code over 12 strokes of a conversion clock. At each stroke it presents a trial code to the capacitive DAC and reads back a single comparator bit. When the last bit is settled, it codes the result as straight binary or two's complement. The input mode decides which.

The conversion clock is a one-cycle enable taken from one of two sources: an internal oscillator tick, or an enable derived from the serial clock. At the accepted start, the block captures the channel-polarity select, the single-ended/differential flag and the bipolar flag. It drives the input multiplexer from these captured values for the whole conversion. The comparator reports whether the held input is at or above the trial value. In bipolar mode the DAC is offset by half scale, so the raw code is offset binary.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, trial_code, result and done are 0, and no conversion is running.
- R2: A start pulse while idle is accepted. On the next clock, trial_code holds only its MSB set (0x800).
- R3: On each conversion-clock enable during a conversion, the bit under trial is kept if cmp_ge is 1 and cleared if it is 0. The next lower bit is then set for trial, MSB first. Between enables, trial_code does not change.
- R4: A conversion ends on exactly the 12th enable. On the following clock, done is 1 for that one cycle only and trial_code returns to 0.
- R5: With clk_src_ext = 1 only scl_en advances the conversion, and with clk_src_ext = 0 only int_tick does. The unselected source has no effect.
- R6: In unipolar coding the result is the settled SAR code as straight binary, 0 to 4095.
- R7: In bipolar coding (differential with bipolar = 1), the result is two's complement, -2048 to +2047. It equals the settled offset-binary code with its MSB (bit 11) inverted.
- R8: In single-ended mode the coding is unipolar whatever bipolar says.
- R9: In unipolar differential mode, a negative differential input gives result 0.
- R10: After an accepted start, mux_pos_ain1 equals the captured chan_sel and mux_neg_gnd equals the captured single_ended flag. In differential mode chan_sel = 1 makes input 1 positive and input 0 negative, and chan_sel = 0 does the reverse.
- R11: Changes on chan_sel, single_ended or bipolar during a conversion have no effect on it. A start during a conversion is ignored.
- R12: The result holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion |
| clk_src_ext | input | 1 | 1 selects scl_en as conversion clock, 0 selects int_tick |
| int_tick | input | 1 | Internal oscillator enable |
| scl_en | input | 1 | Serial-clock derived enable |
| chan_sel | input | 1 | Channel/polarity select |
| single_ended | input | 1 | 1 = single-ended, 0 = differential |
| bipolar | input | 1 | 1 = bipolar coding request |
| cmp_ge | input | 1 | Comparator: held input at or above trial value |
| trial_code | output | 12 | DAC trial code |
| mux_pos_ain1 | output | 1 | 1 = input 1 on the positive side |
| mux_neg_gnd | output | 1 | 1 = ground on the negative side |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 12 | Coded conversion result |

## Verification
The final bit trial and a fresh start request can fall in the same cycle. The bench raises start together with the 12th enable. It then judges that done still arrives on schedule, that trial_code returns to 0 and stays there, and that no second result comes out. A second collision puts a start and changes on all three mode inputs into a mid-conversion enable cycle. The per-step trial codes and the final coded result must then match the values the bench predicts from the mode captured at the original start.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef struct packed {
    logic single_ended;
    logic bipolar;
    logic pos_sel;
  } conv_mode_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } phase_e;

endpackage

// File: rtl/sar_cen_sel.sv
module sar_cen_sel #(
  parameter bit REG_CEN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic int_tick,
  input  logic scl_en,
  output logic cen
);

  logic picked;
  assign picked = ext_sel ? scl_en : int_tick;

  generate
    if (REG_CEN) begin : g_reg
      logic cen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cen_q <= 1'b0;
        else        cen_q <= picked;
      end
      assign cen = cen_q;
    end else begin : g_comb
      assign cen = picked;

      assert_src_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel ? !scl_en : !int_tick) |-> !cen);
    end
  endgenerate

endmodule

// File: rtl/sar_mode_latch.sv
module sar_mode_latch
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       busy,
  input  logic       se_in,
  input  logic       bip_in,
  input  logic       sel_in,
  output conv_mode_t mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (load) begin
      mode_q.single_ended <= se_in;
      mode_q.bipolar      <= bip_in;
      mode_q.pos_sel      <= sel_in;
    end
  end

  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

endmodule

// File: rtl/sar_bit_seq.sv
module sar_bit_seq
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         cen,
  input  logic         cmp_ge,
  output logic [W-1:0] trial,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] raw
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};
  localparam int CW = $clog2(W) + 1;

  phase_e       phase;
  logic [W-1:0] sar_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] decided;
  logic         step;

  assign busy    = (phase == PH_CONV);
  assign step    = busy && cen;
  assign decided = cmp_ge ? sar_q : (sar_q & ~mask_q);
  assign fin     = step && mask_q[0];
  assign raw     = decided;
  assign trial   = sar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sar_q  <= '0;
      mask_q <= '0;
    end else if (!busy) begin
      if (go) begin
        phase  <= PH_CONV;
        sar_q  <= TOP_BIT;
        mask_q <= TOP_BIT;
      end
    end else if (step) begin
      if (mask_q[0]) begin
        phase  <= PH_IDLE;
        sar_q  <= '0;
        mask_q <= '0;
      end else begin
        sar_q  <= decided | (mask_q >> 1);
        mask_q <= mask_q >> 1;
      end
    end
  end

  // enable counter kept for the checks only
  logic [CW-1:0] strokes;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           strokes <= '0;
    else if (go && !busy) strokes <= '0;
    else if (step)        strokes <= strokes + 1'b1;
  end

  assert_one_bit_under_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(mask_q) == 1));

  assert_first_trial_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trial == TOP_BIT));

  assert_trial_held_between_strokes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cen) |=> $stable(trial));

  assert_twelve_strokes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (strokes == CW'(W - 1)));

  assert_trial_cleared_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (trial == '0));

endmodule

// File: rtl/sar_out_coder.sv
module sar_out_coder
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fin,
  input  logic [W-1:0] raw,
  input  conv_mode_t   mode,
  output logic [W-1:0] result,
  output logic         done
);

  // single-ended always codes unipolar
  function automatic logic use_twos(input conv_mode_t m);
    return m.bipolar && !m.single_ended;
  endfunction

  // offset binary to two's complement: flip the sign position
  function automatic logic [W-1:0] apply_coding(input logic [W-1:0] code, input logic twos);
    logic [W-1:0] flip;
    flip = {1'b1, {(W-1){1'b0}}};
    return twos ? (code ^ flip) : code;
  endfunction

  logic twos_now;
  assign twos_now = use_twos(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) result <= apply_coding(raw, twos_now);
    end
  end

  assert_done_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_single_ended_unipolar_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mode.single_ended) |=> (result == $past(raw)));

  assert_bipolar_sign_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mode.bipolar && !mode.single_ended) |=> (result[W-1] != $past(raw[W-1])));

  assert_result_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(result));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int W       = 12,
  parameter bit REG_CEN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         clk_src_ext,
  input  logic         int_tick,
  input  logic         scl_en,
  input  logic         chan_sel,
  input  logic         single_ended,
  input  logic         bipolar,
  input  logic         cmp_ge,
  output logic [W-1:0] trial_code,
  output logic         mux_pos_ain1,
  output logic         mux_neg_gnd,
  output logic         done,
  output logic [W-1:0] result
);

  logic         cen;
  logic         busy;
  logic         accept;
  logic         fin;
  logic [W-1:0] raw;
  conv_mode_t   mode;

  assign accept = start && !busy;

  sar_cen_sel #(.REG_CEN(REG_CEN)) u_cen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (clk_src_ext),
    .int_tick (int_tick),
    .scl_en   (scl_en),
    .cen      (cen)
  );

  sar_mode_latch u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .busy   (busy),
    .se_in  (single_ended),
    .bip_in (bipolar),
    .sel_in (chan_sel),
    .mode_q (mode)
  );

  sar_bit_seq #(.W(W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (accept),
    .cen    (cen),
    .cmp_ge (cmp_ge),
    .trial  (trial_code),
    .busy   (busy),
    .fin    (fin),
    .raw    (raw)
  );

  sar_out_coder #(.W(W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .fin    (fin),
    .raw    (raw),
    .mode   (mode),
    .result (result),
    .done   (done)
  );

  assign mux_pos_ain1 = mode.pos_sel;
  assign mux_neg_gnd  = mode.single_ended;

  assert_mux_follows_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mux_pos_ain1 == $past(chan_sel) && mux_neg_gnd == $past(single_ended)));

  assert_start_ignored_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin) |=> (trial_code != '0));

endmodule

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        clk_src_ext = 1'b0;
  logic        int_tick = 1'b0;
  logic        scl_en = 1'b0;
  logic        chan_sel = 1'b0;
  logic        single_ended = 1'b0;
  logic        bipolar = 1'b0;
  logic        cmp_ge;
  logic [11:0] trial_code;
  logic        mux_pos_ain1;
  logic        mux_neg_gnd;
  logic        done;
  logic [11:0] result;

  always #2 clk = ~clk;

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .clk_src_ext  (clk_src_ext),
    .int_tick     (int_tick),
    .scl_en       (scl_en),
    .chan_sel     (chan_sel),
    .single_ended (single_ended),
    .bipolar      (bipolar),
    .cmp_ge       (cmp_ge),
    .trial_code   (trial_code),
    .mux_pos_ain1 (mux_pos_ain1),
    .mux_neg_gnd  (mux_neg_gnd),
    .done         (done),
    .result       (result)
  );

  // ideal comparator: analog inputs in LSB units, DAC offset by half scale when bipolar
  int ain0_v = 0;
  int ain1_v = 0;
  int dac_off = 0;
  always_comb begin
    int vp;
    int vn;
    vp = mux_pos_ain1 ? ain1_v : ain0_v;
    vn = mux_neg_gnd ? 0 : (mux_pos_ain1 ? ain0_v : ain1_v);
    cmp_ge = ((vp - vn) + dac_off) >= int'(trial_code);
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: each done pops one expected result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", int'(result), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(result) == e, t, int'(result), e);
      end
    end
  end

  int last_exp = 0;

  task automatic convert(input int x0, input int x1, input bit cs, input bit se, input bit bip,
                         input bit ext, input int gap, input bit disturb, input bit late_start,
                         input string tag);
    int vp, vn, v, target, expv, s;
    bit twos;
    vp = cs ? x1 : x0;
    vn = se ? 0 : (cs ? x0 : x1);
    v = vp - vn;
    twos = bip && !se;
    if (twos) begin
      s = (v < -2048) ? -2048 : ((v > 2047) ? 2047 : v);
      expv = s & 32'hFFF;
      target = s + 2048;
    end else begin
      s = (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
      expv = s;
      target = s;
    end
    last_exp = expv;
    exp_q.push_back(expv);
    tag_q.push_back(tag);

    @(negedge clk);
    ain0_v = x0; ain1_v = x1; dac_off = twos ? 2048 : 0;
    chan_sel = cs; single_ended = se; bipolar = bip; clk_src_ext = ext;
    int_tick = 1'b0; scl_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // unselected source held high through the conversion
    if (ext) int_tick = 1'b1; else scl_en = 1'b1;
    check(trial_code == 12'h800, "R2 first trial", int'(trial_code), 12'h800);
    check(mux_pos_ain1 == cs && mux_neg_gnd == se, "R10 mux capture",
          {mux_pos_ain1, mux_neg_gnd}, {cs, se});
    for (int k = 0; k < 12; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(done == 1'b0, "R5 unselected source ignored", done, 0);
      end
      if (ext) scl_en = 1'b1; else int_tick = 1'b1;
      if (disturb && k == 5) begin
        start = 1'b1; chan_sel = ~cs; single_ended = ~se; bipolar = ~bip;
      end
      if (late_start && k == 11) start = 1'b1;
      @(negedge clk);
      if (ext) scl_en = 1'b0; else int_tick = 1'b0;
      start = 1'b0;
      if (k < 11) begin
        int up, et;
        up = (target >> (11 - k)) << (11 - k);
        et = up | (1 << (10 - k));
        check(int'(trial_code) == et, "R3 trial step", int'(trial_code), et);
        check(done == 1'b0, "R4 no early done", done, 0);
      end else begin
        check(done == 1'b1, "R4 done after 12th enable", done, 1);
        check(trial_code == 12'h000, "R4 trial cleared", int'(trial_code), 0);
      end
    end
    int_tick = 1'b0; scl_en = 1'b0;
    chan_sel = cs; single_ended = se; bipolar = bip;
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", done, 0);
    if (late_start)
      check(trial_code == 12'h000, "R11 start at last trial ignored", int'(trial_code), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trial_code == 0 && done == 0 && result == 0, "R1 reset state",
          int'(trial_code) + int'(done) + int'(result), 0);

    convert(1234, 0,    1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R6 single-ended ch0");
    convert(0,    5000, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0, "R5 R6 ext clock over-range");
    convert(3000, 1000, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6 differential unipolar");
    convert(100,  900,  1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R9 negative input clamps");
    convert(100,  900,  1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10 swapped polarity");
    convert(1000, 1500, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R7 bipolar negative");
    convert(3000, 1000, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, "R7 bipolar positive");
    convert(0,    3000, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R7 bipolar low limit");
    convert(4095, 2048, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R7 bipolar high limit");
    convert(3000, 0,    1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R8 single-ended ignores bipolar");
    convert(2500, 700,  1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0, "R11 mid-conversion disturbance");
    convert(1777, 0,    1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1, "R11 late start result");

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      int_tick = ~int_tick; scl_en = ~scl_en;
    end
    @(negedge clk);
    check(int'(result) == last_exp, "R12 result held", int'(result), last_exp);
    check(exp_q.size() == 0, "R4 every conversion produced done", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule